// File: doc/BRIEF.md
# Interrupt Event Collector

This block gathers single-cycle event pulses from five internal sources of a peripheral into a sticky status register. It holds a mask of the same width and raises an interrupt request whenever a pending flag is also enabled. The sources are the two interval timers, the time-of-day alarm, the serial shifter and an external flag pin.

Software reaches the block through two strobes that the surrounding address decoder supplies. A mask write uses data bit 7 as a set/clear selector. The read data byte always presents the status view: the flags in the low bits and a summary bit in bit 7. A cycle with the read strobe high marks the read as consumed and clears every flag at the following clock edge. An event that arrives in that same cycle is not lost.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), all flags and all mask bits are zero, rd_data_o reads 8'h00 and irq_o is low.
- R2: An event pulse on evt_i[k] sets flag k at the next rising edge, and rd_data_o[k] shows it. The bit mapping is: bit 0 is the first timer underflow, bit 1 the second timer underflow, bit 2 the time-of-day alarm, bit 3 serial byte complete, and bit 4 the external flag pin.
- R3: A mask write (mask_wr_i high) with wr_data_i[7] = 1 sets every mask bit k for which wr_data_i[k] = 1.
- R4: A mask write with wr_data_i[7] = 0 clears every mask bit k for which wr_data_i[k] = 1. In both kinds of write, a mask bit whose data bit is 0 keeps its value.
- R5: rd_data_o[7] is 1 exactly when the bitwise AND of flags and mask is nonzero. rd_data_o[6:5] read 0.
- R6: irq_o is registered and equals, one edge later, the value of the condition in R5.
- R7: A cycle with stat_rd_i high clears every flag at the next rising edge.
- R8: An event pulse in the same cycle as stat_rd_i sets its flag after that edge, despite the clear.
- R9: Flags are sticky. Without a read they stay set through any number of cycles and any mask value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 5 | Single-cycle event pulses, one per source |
| mask_wr_i | input | 1 | Mask write strobe |
| stat_rd_i | input | 1 | Status read strobe; clears flags at the next edge |
| wr_data_i | input | 8 | Write data; bit 7 selects set (1) or clear (0) |
| rd_data_o | output | 8 | Status view: flags in [4:0], summary in [7] |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
An event, a mask write or a read clear takes effect at the first rising edge after the stimulus. Because rd_data_o is combinational from the registers, the flags and the summary bit are due right after that edge. irq_o follows one edge later. The bench applies every stimulus at a falling edge and compares all outputs at the next falling edge. Its reference model advances the expected request from the pre-edge flags and mask, so the one-cycle lag of irq_o is checked in every cycle.

// File: rtl/evt_irq_pkg.sv
// Package: shared source indices and sizes for the interrupt event collector.
// Assumes: source order is fixed, because software decodes these bit positions.
package evt_irq_pkg;
    localparam int SRC_TMR_A  = 0;
    localparam int SRC_TMR_B  = 1;
    localparam int SRC_ALARM  = 2;
    localparam int SRC_SERIAL = 3;
    localparam int SRC_FLAG   = 4;
    localparam int NUM_SRC    = 5;
    localparam int REG_W      = 8;
endpackage

// File: rtl/evt_flag_bank.sv
// Module: sticky flag bank. Each flag is set by its event pulse and cleared by
// a read strobe; an event has priority over the clear in the same cycle.
// Assumes: event pulses are synchronous to clk.
module evt_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    for (genvar k = 0; k < N; k++) begin : g_flag
        // Set on event, clear on read, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)        flags_q[k] <= 1'b0;
            else if (evt_i[k]) flags_q[k] <= 1'b1;
            else if (clr_i)    flags_q[k] <= 1'b0;
        end
    end

    assign flags_o = flags_q;

    // R7
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((flags_q & ~$past(evt_i)) == '0));
    // R8
    evt_survives_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));
    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/evt_mask_reg.sv
// Module: enable mask with set/clear write. The top data bit picks set or
// clear. The low N data bits select which mask bits are affected.
// Assumes: N is less than DW, so the selector bit is distinct from the selects.
module evt_mask_reg #(
    parameter int N  = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] data_i,
    output logic [N-1:0]  mask_o
);
    logic [N-1:0] mask_q;
    logic [N-1:0] sel;
    logic         set_mode;

    // Split write data into selector and affected bits.
    always_comb begin
        set_mode = data_i[DW-1];
        sel      = data_i[N-1:0];
    end

    // Apply the set or the clear to the selected bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (wr_i) begin
            if (set_mode)  mask_q <= mask_q | sel;
            else           mask_q <= mask_q & ~sel;
        end
    end

    assign mask_o = mask_q;

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && data_i[DW-1]) |=> ((mask_q & $past(data_i[N-1:0])) == $past(data_i[N-1:0])));
    // R4
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !data_i[DW-1]) |=> ((mask_q & $past(data_i[N-1:0])) == '0));
    // R4
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((mask_q & ~$past(data_i[N-1:0])) == ($past(mask_q) & ~$past(data_i[N-1:0]))));
endmodule

// File: rtl/evt_req_gen.sv
// Module: builds the status read view with its summary bit and registers the
// interrupt request from the same condition.
// Assumes: flags and mask come straight from registers.
module evt_req_gen #(
    parameter int N  = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  flags_i,
    input  logic [N-1:0]  mask_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_o
);
    logic any_en;
    logic irq_q;

    // Summary condition and read view, unused middle bits at zero.
    always_comb begin
        any_en              = |(flags_i & mask_i);
        rd_data_o           = '0;
        rd_data_o[N-1:0]    = flags_i;
        rd_data_o[DW-1]     = any_en;
    end

    // Register the request one cycle behind the summary condition.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_en;
    end

    assign irq_o = irq_q;

    // R6
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == $past(|(flags_i & mask_i))));
endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: top of the interrupt event collector. Wires the flag bank, the mask
// register and the request generator to the register strobes.
// Assumes: the address decoder supplies one-cycle mask_wr_i and stat_rd_i strobes.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_i,
    input  logic          mask_wr_i,
    input  logic          stat_rd_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_o
);
    logic [N-1:0] flags;
    logic [N-1:0] mask;

    evt_flag_bank #(.N(N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .clr_i   (stat_rd_i),
        .flags_o (flags)
    );

    evt_mask_reg #(.N(N), .DW(DW)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mask_wr_i),
        .data_i (wr_data_i),
        .mask_o (mask)
    );

    evt_req_gen #(.N(N), .DW(DW)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_i   (flags),
        .mask_i    (mask),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data_o == '0 && !irq_o));
    // R5
    summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DW-1] == |(rd_data_o[N-1:0] & mask));
endmodule

// File: tb/evt_irq_ctrl_bench.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// reference model of flags, mask and request.
module evt_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] evt_i;
    logic       mask_wr_i;
    logic       stat_rd_i;
    logic [7:0] wr_data_i;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [4:0] m_flags = '0;
    logic [4:0] m_mask  = '0;
    logic       m_irq   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .mask_wr_i (mask_wr_i),
        .stat_rd_i (stat_rd_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    function automatic logic [7:0] view(input logic [4:0] f, input logic [4:0] m);
        return {|(f & m), 2'b00, f};
    endfunction

    function automatic logic [4:0] next_mask(input logic [4:0] m, input logic [7:0] d);
        return d[7] ? (m | d[4:0]) : (m & ~d[4:0]);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, advance the model, compare at the next falling edge.
    task automatic step(input string tag, input logic [4:0] e, input logic w,
                        input logic r, input logic [7:0] d);
        logic [4:0] nf;
        logic [4:0] nm;
        logic       ni;
        evt_i = e; mask_wr_i = w; stat_rd_i = r; wr_data_i = d;
        ni = |(m_flags & m_mask);
        nf = (r ? 5'b0 : m_flags) | e;
        nm = w ? next_mask(m_mask, d) : m_mask;
        @(posedge clk);
        @(negedge clk);
        m_flags = nf; m_mask = nm; m_irq = ni;
        evt_i = '0; mask_wr_i = 1'b0; stat_rd_i = 1'b0; wr_data_i = '0;
        check(tag, rd_data_o, view(m_flags, m_mask));
        check("R6", {7'b0, irq_o}, {7'b0, m_irq});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; evt_i = '0; mask_wr_i = 1'b0; stat_rd_i = 1'b0; wr_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", rd_data_o, 8'h00);
        check("R1", {7'b0, irq_o}, 8'h00);

        // R2: each source sets its own bit, mask zero, then read clears
        for (int k = 0; k < 5; k++) begin
            step("R2", 5'(1 << k), 1'b0, 1'b0, 8'h00);
            check("R2", rd_data_o, 8'(1 << k));
            step("R7", 5'b0, 1'b0, 1'b1, 8'h00);
        end

        // R9: flags stay set without a read, mask zero
        step("R9", 5'b10110, 1'b0, 1'b0, 8'h00);
        repeat (4) step("R9", 5'b0, 1'b0, 1'b0, 8'h00);
        check("R9", rd_data_o, 8'h16);

        // R3: set mask bits 1 and 4 -> summary high, request one edge later
        step("R3", 5'b0, 1'b1, 1'b0, 8'h92);
        check("R3", rd_data_o, 8'h96);
        step("R6", 5'b0, 1'b0, 1'b0, 8'h00);
        check("R6", {7'b0, irq_o}, 8'h01);

        // R4: clear bits 1 and 4 (bit 2 select hits an already-clear bit), summary drops
        step("R4", 5'b0, 1'b1, 1'b0, 8'h16);
        check("R4", rd_data_o, 8'h16);
        // R4: set bit 2, then clear bit 0 only; bit 2 must survive
        step("R4", 5'b0, 1'b1, 1'b0, 8'h84);
        step("R4", 5'b0, 1'b1, 1'b0, 8'h01);
        check("R4", rd_data_o, 8'h96);

        // R8: event during a read survives the clear
        step("R8", 5'b01000, 1'b0, 1'b1, 8'h00);
        check("R8", rd_data_o, 8'h08);
        step("R7", 5'b0, 1'b0, 1'b1, 8'h00);
        check("R7", rd_data_o, 8'h00);

        // R5/R6: seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] e;
            e = '0;
            for (int b = 0; b < 5; b++) e[b] = (($urandom % 8) == 0);
            step("R5", e, (($urandom % 6) == 0), (($urandom % 7) == 0), 8'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule